// File: doc/BRIEF.md
# Active Serial Configuration Loader

This block is the master side of a four-wire serial link to an external nonvolatile memory that holds a configuration bitstream. After reset it keeps a status line low for a programmable settling time. It then selects the memory, clocks out a read opcode and a start address, and streams the stored bits back in. The bits are packed into bytes and handed to an internal configuration consumer over a valid/ready handshake. The serial clock is derived from the system clock by a divider chosen to fall between 14 and 20 MHz.

Once the programmed number of bytes has arrived and the last one has been taken, the block deselects the memory and raises a configured flag. It then counts a fixed number of initialization clock periods on its internal serial clock while the pin stays low. At the end it raises the initialization-done flag and enables user I/O, which stays disabled until that point.

The controller is a six-state machine:
- `ST_POR` is the settling wait. It moves to `ST_CMD` when the settling timer expires.
- `ST_CMD` shifts out the command. It moves to `ST_DATA` on the falling edge after the 32nd rising edge.
- `ST_DATA` receives the stream. It moves to `ST_FINISH` on the rising edge that completes the last byte.
- `ST_FINISH` moves to `ST_INIT` once the clock is low and the last byte has been accepted.
- `ST_INIT` moves to `ST_USER` on the last initialization rising edge.
- `ST_USER` is terminal.

Top module: `as_cfg_loader`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `status_n`, `cfg_done`, `init_done`, `user_io_en`, `flash_sck` and `byte_valid` are 0, and `flash_cs_n` is 1.
- R2: `status_n` stays low after reset release and goes high exactly POR_WAIT+1 clock edges after release. It then stays high until the next reset.
- R3: While `flash_cs_n` is low, each high phase of `flash_sck` lasts HALF_DIV system clocks. Each low phase lasts at least HALF_DIV system clocks, and exactly HALF_DIV when no byte is waiting for acceptance.
- R4: `flash_mosi` changes only while `flash_sck` is low. The first 32 bits latched on rising edges are the read opcode 0x03 followed by the 24-bit START_ADDR, most significant bit first.
- R5: `flash_cs_n` is low only while `status_n` is high. Once it falls it stays low, without interruption, until 32 + 8·TOTAL_BYTES rising edges have been issued.
- R6: Received bits are sampled on rising edges and packed most significant bit first. Bytes appear on `byte_data` in memory order, and `byte_data` stays stable while `byte_valid` is high and `byte_ready` is low.
- R7: While an unaccepted byte is held, at most 7 further rising edges occur. No received byte is lost or repeated.
- R8: Whenever `flash_cs_n` is high, `flash_sck` is low. `cfg_done` rises only after all TOTAL_BYTES bytes have been accepted, with the memory deselected.
- R9: `init_done` rises exactly HALF_DIV·(2·INIT_CLKS−1)+1 system clocks after `cfg_done` rises, with INIT_CLKS = 136 by default. `cfg_done` stays high throughout.
- R10: `user_io_en` equals `init_done` at all times, so user I/O is disabled until initialization ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_sck | output | 1 | Serial clock to the memory |
| flash_cs_n | output | 1 | Memory select, active low |
| flash_mosi | output | 1 | Command/address bit to the memory |
| flash_miso | input | 1 | Data bit from the memory |
| status_n | output | 1 | Low while settling after reset |
| cfg_done | output | 1 | All configuration data received |
| init_done | output | 1 | Initialization clocks finished |
| user_io_en | output | 1 | User I/O enable |
| byte_data | output | 8 | Received configuration byte |
| byte_valid | output | 1 | `byte_data` holds an unaccepted byte |
| byte_ready | input | 1 | Consumer accepts the byte |

## Verification
The hardest situation to reach is a full stall. This happens when a byte is still held at the output just as the next byte finishes arriving, so the serial clock must freeze low between the seventh and eighth bits. A consumer that accepts promptly never gets there. The bench therefore withholds `byte_ready` for a varying number of cycles per byte, including one hold of 200 cycles, and counts rising edges during each hold. A second run resets the block in the middle of the data phase, then repeats the sequence with an always-ready consumer so that every low phase can be timed exactly.

// File: rtl/as_cfg_pkg.sv
package as_cfg_pkg;

    typedef enum logic [2:0] {
        ST_POR,
        ST_CMD,
        ST_DATA,
        ST_FINISH,
        ST_INIT,
        ST_USER
    } ld_state_t;

    localparam int unsigned CMD_BITS  = 32;
    localparam logic [7:0]  RD_OPCODE = 8'h03;

endpackage

// File: rtl/as_sck_gen.sv
module as_sck_gen #(
    parameter int unsigned HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_q,
    output logic rise_p,
    output logic fall_p
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // A high phase always completes; a low phase only ends while run is set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sck_q  <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (sck_q) begin
                if (cnt == LAST) begin
                    sck_q  <= 1'b0;
                    fall_p <= 1'b1;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (!run) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                sck_q  <= 1'b1;
                rise_p <= 1'b1;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/as_por_timer.sv
module as_por_timer #(
    parameter int unsigned POR_WAIT = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned PW = $clog2(POR_WAIT + 1);
    localparam logic [PW-1:0] LAST = PW'(POR_WAIT - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/as_rx_packer.sv
module as_rx_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       bit_in,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       last_bit
);
    logic [6:0] sr;
    logic [2:0] bcnt;

    assign last_bit = (bcnt == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            bcnt      <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (shift_en) begin
                sr   <= {sr[5:0], bit_in};
                bcnt <= bcnt + 1'b1;
                if (last_bit) begin
                    out_data  <= {sr, bit_in};
                    out_valid <= 1'b1;
                end
            end
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && last_bit) |-> !out_valid);

endmodule

// File: rtl/as_cfg_loader.sv
module as_cfg_loader
    import as_cfg_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 3,
    parameter int unsigned POR_WAIT    = 10_000_000,
    parameter int unsigned TOTAL_BYTES = 65536,
    parameter logic [23:0] START_ADDR  = 24'h000000,
    parameter int unsigned INIT_CLKS   = 136
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       flash_sck,
    output logic       flash_cs_n,
    output logic       flash_mosi,
    input  logic       flash_miso,
    output logic       status_n,
    output logic       cfg_done,
    output logic       init_done,
    output logic       user_io_en,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    input  logic       byte_ready
);
    localparam int unsigned BCW = $clog2(TOTAL_BYTES + 1);
    localparam int unsigned ICW = $clog2(INIT_CLKS + 1);
    localparam logic [31:0] CMD_WORD = {RD_OPCODE, START_ADDR};
    localparam logic [5:0] CMD_LAST = 6'(CMD_BITS);

    ld_state_t state, nxt;

    logic           sck_q, rise_p, fall_p, run;
    logic           por_done;
    logic           shift_en, last_bit;
    logic           cs_n_int;
    logic [31:0]    cmd_sr;
    logic [5:0]     cmd_cnt;
    logic [BCW-1:0] byte_cnt;
    logic [ICW-1:0] init_cnt;

    as_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sck_q  (sck_q),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    as_por_timer #(.POR_WAIT(POR_WAIT)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (por_done)
    );

    as_rx_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .bit_in    (flash_miso),
        .out_ready (byte_ready),
        .out_data  (byte_data),
        .out_valid (byte_valid),
        .last_bit  (last_bit)
    );

    assign shift_en = rise_p && (state == ST_DATA);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_POR;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_POR:    if (por_done) nxt = ST_CMD;
            ST_CMD:    if (fall_p && cmd_cnt == CMD_LAST) nxt = ST_DATA;
            ST_DATA:   if (shift_en && last_bit &&
                           byte_cnt == BCW'(TOTAL_BYTES - 1)) nxt = ST_FINISH;
            ST_FINISH: if (!sck_q && !byte_valid) nxt = ST_INIT;
            ST_INIT:   if (rise_p && init_cnt == ICW'(INIT_CLKS - 1)) nxt = ST_USER;
            ST_USER:   nxt = ST_USER;
            default:   nxt = ST_POR;
        endcase
    end

    // Counters and command shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sr   <= CMD_WORD;
            cmd_cnt  <= '0;
            byte_cnt <= '0;
            init_cnt <= '0;
        end else begin
            case (state)
                ST_POR: begin
                    cmd_sr   <= CMD_WORD;
                    cmd_cnt  <= '0;
                    byte_cnt <= '0;
                    init_cnt <= '0;
                end
                ST_CMD: begin
                    if (rise_p) cmd_cnt <= cmd_cnt + 1'b1;
                    if (fall_p) cmd_sr  <= {cmd_sr[30:0], 1'b0};
                end
                ST_DATA: begin
                    if (shift_en && last_bit) byte_cnt <= byte_cnt + 1'b1;
                end
                ST_INIT: begin
                    if (rise_p) init_cnt <= init_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        status_n   = 1'b1;
        cfg_done   = 1'b0;
        init_done  = 1'b0;
        user_io_en = 1'b0;
        cs_n_int   = 1'b1;
        run        = 1'b0;
        flash_mosi = 1'b0;
        unique case (state)
            ST_POR: begin
                status_n = 1'b0;
            end
            ST_CMD: begin
                cs_n_int   = 1'b0;
                run        = 1'b1;
                flash_mosi = cmd_sr[31];
            end
            ST_DATA: begin
                cs_n_int = 1'b0;
                run      = !(byte_valid && last_bit);
            end
            ST_FINISH: begin
                cs_n_int = 1'b0;
            end
            ST_INIT: begin
                cfg_done = 1'b1;
                run      = 1'b1;
            end
            ST_USER: begin
                cfg_done   = 1'b1;
                init_done  = 1'b1;
                user_io_en = 1'b1;
            end
            default: ;
        endcase
    end

    assign flash_cs_n = cs_n_int;
    assign flash_sck  = sck_q && !cs_n_int;

    // R5
    cs_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> status_n);

    // R4
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs_n && !$past(flash_cs_n) && flash_sck) |-> $stable(flash_mosi));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (flash_cs_n && !flash_sck));

    // R9
    init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (cfg_done && $past(cfg_done)));

endmodule

// File: tb/test_as_cfg_loader.sv
module test_as_cfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF   = 3;
    localparam int PWAIT  = 40;
    localparam int NBYTES = 12;
    localparam int INITC  = 136;
    localparam logic [23:0] SADDR = 24'h01A2C0;

    logic clk = 1'b0;
    logic rst_n;
    logic flash_sck, flash_cs_n, flash_mosi, flash_miso;
    logic status_n, cfg_done, init_done, user_io_en;
    logic [7:0] byte_data;
    logic byte_valid, byte_ready;

    always #(CLK_PERIOD / 2) clk = ~clk;

    as_cfg_loader #(
        .HALF_DIV(HALF), .POR_WAIT(PWAIT), .TOTAL_BYTES(NBYTES),
        .START_ADDR(SADDR), .INIT_CLKS(INITC)
    ) i_as_cfg_loader (
        .clk(clk), .rst_n(rst_n),
        .flash_sck(flash_sck), .flash_cs_n(flash_cs_n),
        .flash_mosi(flash_mosi), .flash_miso(flash_miso),
        .status_n(status_n), .cfg_done(cfg_done), .init_done(init_done),
        .user_io_en(user_io_en), .byte_data(byte_data),
        .byte_valid(byte_valid), .byte_ready(byte_ready)
    );

    int vectors = 0;
    int fails = 0;
    int timeouts = 0;
    int ready_mode = 1;
    bit strict_low = 1'b0;

    // Monitor and memory model state
    int cyc = 0, rcnt = 0, recv = 0, hi_run = 0, lo_run = 0;
    int stall_rises = 0, wait_ctr = 0, cfg_t = 0;
    bit init_seen = 1'b0;
    logic prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    logic prev_cfg = 1'b0, prev_init = 1'b0, prev_hold = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic [31:0] cmd_cap = 32'h0;

    function automatic logic [7:0] mem_byte(input int k);
        logic [31:0] v;
        v = (k * 53 + 17) ^ (k << 3);
        return v[7:0] ^ SADDR[7:0];
    endfunction

    function automatic int hold_lim(input int k);
        if (k == 4) return 200;
        return (k * 7) % 13;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(status_n == 1'b0 && cfg_done == 1'b0 && init_done == 1'b0 &&
                user_io_en == 1'b0 && flash_cs_n == 1'b1 && flash_sck == 1'b0 &&
                byte_valid == 1'b0, "R1",
                {status_n, cfg_done, init_done, user_io_en, flash_cs_n, flash_sck, byte_valid},
                7'b0000100);
            cyc = 0; rcnt = 0; recv = 0; hi_run = 0; lo_run = 0;
            stall_rises = 0; wait_ctr = 0; init_seen = 1'b0;
            prev_sck = 1'b0; prev_cs = 1'b1; prev_mosi = 1'b0;
            prev_cfg = 1'b0; prev_init = 1'b0; prev_hold = 1'b0;
            byte_ready = 1'b0; flash_miso = 1'b0;
        end else begin
            logic r_new;
            cyc++;
            // R2 status release time
            chk(status_n == (cyc >= PWAIT + 1), "R2", status_n, (cyc >= PWAIT + 1));
            // R8 clock quiet while deselected
            if (flash_cs_n) chk(!flash_sck, "R8", flash_sck, 0);
            // R5 select only after status release
            if (!flash_cs_n) chk(status_n, "R5", status_n, 1);
            // R10
            chk(user_io_en == init_done, "R10", user_io_en, init_done);
            // R4 command bit changes only in low phase
            if (!flash_cs_n && !prev_cs && flash_mosi != prev_mosi)
                chk(!flash_sck && !prev_sck, "R4", flash_sck, 0);
            // R6 hold stability
            if (prev_hold) begin
                chk(byte_valid, "R6", byte_valid, 1);
                chk(byte_data == prev_data, "R6", byte_data, prev_data);
            end
            // clock edges seen at the pin
            if (flash_sck && !prev_sck) begin
                if (strict_low) chk(lo_run == HALF, "R3", lo_run, HALF);
                else chk(lo_run >= HALF, "R3", lo_run, HALF);
                lo_run = 0;
                if (rcnt < 32) cmd_cap = {cmd_cap[30:0], flash_mosi};
                rcnt++;
                if (rcnt == 32) chk(cmd_cap == {8'h03, SADDR}, "R4", cmd_cap, {8'h03, SADDR});
                if (byte_valid) begin
                    stall_rises++;
                    chk(stall_rises <= 7, "R7", stall_rises, 7);
                end
            end
            if (!flash_sck && prev_sck) begin
                chk(hi_run == HALF, "R3", hi_run, HALF);
                if (rcnt >= 32) begin
                    int idx;
                    logic [7:0] b;
                    idx = rcnt - 32;
                    b = mem_byte(idx / 8);
                    flash_miso = b[7 - (idx % 8)];
                end
            end
            if (flash_sck) hi_run++; else hi_run = 0;
            if (!flash_cs_n && !flash_sck) lo_run++;
            if (flash_cs_n) lo_run = 0;
            if (!byte_valid) stall_rises = 0;
            // R5 select held for the whole transfer
            if (flash_cs_n && !prev_cs)
                chk(rcnt == 32 + 8 * NBYTES, "R5", rcnt, 32 + 8 * NBYTES);
            if (flash_cs_n) rcnt = 0;
            // R9 / R8 completion
            if (cfg_done && !prev_cfg) begin
                chk(recv == NBYTES, "R8", recv, NBYTES);
                cfg_t = cyc;
            end
            if (init_done && !prev_init) begin
                chk(cfg_done && (cyc - cfg_t) == HALF * (2 * INITC - 1) + 1, "R9",
                    cyc - cfg_t, HALF * (2 * INITC - 1) + 1);
                init_seen = 1'b1;
            end
            if (prev_init) chk(init_done && cfg_done, "R9", init_done, 1);
            // consumer
            if (ready_mode == 0) r_new = 1'b1;
            else if (byte_valid && wait_ctr < hold_lim(recv)) begin
                r_new = 1'b0;
                wait_ctr++;
            end else r_new = byte_valid;
            if (byte_valid && r_new) begin
                chk(byte_data == mem_byte(recv), "R6", byte_data, mem_byte(recv));
                recv++;
                wait_ctr = 0;
            end
            prev_hold = byte_valid && !r_new;
            prev_data = byte_data;
            byte_ready = r_new;
            prev_sck = flash_sck; prev_cs = flash_cs_n; prev_mosi = flash_mosi;
            prev_cfg = cfg_done; prev_init = init_done;
        end
    end

    task automatic apply_reset();
        @(negedge clk); #1; rst_n = 1'b0;
        repeat (5) @(negedge clk);
        #1; rst_n = 1'b1;
    endtask

    task automatic wait_init();
        int guard = 0;
        while (!init_seen && guard < 30000) begin
            @(posedge clk);
            guard++;
        end
        if (!init_seen) begin
            timeouts++;
            $display("FAIL R9: actual timeout expected init_done");
        end
        repeat (20) @(posedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        byte_ready = 1'b0;
        flash_miso = 1'b0;
        // Run A: irregular consumer with a long stall
        ready_mode = 1; strict_low = 1'b0;
        apply_reset();
        wait_init();
        // Run B: always-ready consumer, reset in mid-stream, then full run
        ready_mode = 0; strict_low = 1'b1;
        apply_reset();
        begin
            int guard = 0;
            while (recv < 3 && guard < 20000) begin
                @(posedge clk);
                guard++;
            end
        end
        apply_reset();
        wait_init();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails + timeouts);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails + timeouts + 1);
        $finish;
    end

endmodule